// File: doc/BRIEF.md
# SPI Panel Register Write Sequencer

This block writes 16-bit values into the internal registers of an LCD panel controller over a write-only SPI link. Each register write becomes two separate 24-bit transfers, each framed by its own chip-select assertion. The first transfer picks the register index. The second carries the value. Chip select is released between the two transfers.

Register writes arrive on a valid/ready stream that carries an 8-bit index and a 16-bit value. The stream uses a simple handshake. A write is taken on a clock edge where `req_valid` and `req_ready` are both high, and the index and value are captured at that edge. While a write is in flight, `req_ready` stays low. A producer holding `req_valid` high therefore simply waits, and it may change its data freely once its word has been taken.

Two control pulses start built-in sequences. `pwr_on` wakes the panel and programs its scan and colour-order word from `cfg_mode`. `pwr_off` puts the panel into shutdown. A serial clock divider sets the SCK rate from the system clock.

Top module: `panel_regwr_seq`

## Requirements
- R1: A register write first sends a select frame. The frame is 24 bits, most significant bit first: byte 0x74, then 0x00, then the 8-bit index. Exactly 24 SCK rising edges occur while chip select is low.
- R2: The second frame of a write is 24 bits, most significant bit first: byte 0x76, then the value's upper byte, then its lower byte. Exactly 24 SCK rising edges occur while chip select is low.
- R3: The link uses SPI mode 3. SCK is high whenever chip select is deasserted (high). MOSI changes only while SCK is low, so it is stable across every rising edge. Each SCK level lasts `CLK_DIV` clock cycles.
- R4: Between any two frames, chip select stays high for at least one full SCK period (2*`CLK_DIV` clock cycles).
- R5: A request is accepted on a clock edge with `req_valid` and `req_ready` both high. Index and value are captured at that edge. `busy` is high in the next cycle, and `req_ready` is low whenever `busy` is high.
- R6: `busy` stays high while either frame is on the wire. `done` is a one-cycle pulse after the second frame ends, and `busy` is still high in that cycle. After a single write, `busy` is low in the cycle after `done`.
- R7: A `pwr_on` pulse writes register 0x11 with 0x0000 and then register 0x01. Each write gives one `done` pulse. The register 0x01 value is 0x00EF with these bits ORed in: `cfg_mode[0]` → bit 8 (left-to-right scan), `cfg_mode[1]` → bit 9 (top-to-bottom scan), `cfg_mode[2]` → bit 11 (BGR order), `cfg_mode[3]` → bit 13 (normal, not reversed).
- R8: A `pwr_off` pulse writes register 0x11 with 0x0001 (shutdown bit 0 set).
- R9: When the block is idle, `pwr_on` has priority over `pwr_off`, and `pwr_off` has priority over the stream. `req_ready` is low in any cycle where either pulse input is high. Both pulse inputs are ignored while `busy` is high.
- R10: After reset: `spi_cs_n`=1, `spi_sck`=1, `busy`=0, `done`=0, `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a write request this cycle |
| req_index | input | 8 | Panel register index |
| req_value | input | 16 | Value to write |
| pwr_on | input | 1 | Pulse: run the wake-up write sequence |
| pwr_off | input | 1 | Pulse: write the shutdown bit |
| cfg_mode | input | 4 | Scan and colour-order bits for register 0x01 |
| busy | output | 1 | A write or sequence is in progress |
| done | output | 1 | One-cycle pulse when a register write completes |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the panel |

## Verification
The bound checker watches the wire-level rules on every cycle:
- SCK is high while chip select is high.
- MOSI is stable while SCK is high.
- Each frame has exactly 24 rising edges.
- Chip select stays high long enough between frames.

It also checks the handshake and status rules on every cycle: `ready` excludes `busy`, `done` is a single pulse that falls inside `busy`, and the power pulses hold `ready` low.

Only the bench's scenarios can show that the bits in each frame carry the right command bytes, index and value. The same holds for the register 0x01 word across all sixteen mode settings, for the ordering of the power-on pair, for the priority among simultaneous inputs, and for the fact that power pulses given mid-write produce no extra frames.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;
  localparam int CMD_W   = 8;
  localparam int IDX_W   = 8;
  localparam int VAL_W   = 16;
  localparam int FRAME_W = CMD_W + VAL_W;
  localparam int MODE_W  = 4;

  localparam logic [CMD_W-1:0] SEL_LEAD = 8'h74;
  localparam logic [CMD_W-1:0] DAT_LEAD = 8'h76;
  localparam logic [IDX_W-1:0] PWR_REG  = 8'h11;
  localparam logic [IDX_W-1:0] OUT_REG  = 8'h01;
  localparam logic [VAL_W-1:0] OUT_BASE = 16'h00EF;
  localparam logic [VAL_W-1:0] PWR_WAKE = 16'h0000;
  localparam logic [VAL_W-1:0] PWR_DOWN = 16'h0001;

  typedef enum logic [2:0] {SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH, SH_GAP} sh_state_e;
  typedef enum logic [1:0] {P_IDLE, P_SEL, P_DAT} pair_state_e;
  typedef enum logic [1:0] {C_IDLE, C_ON_A, C_WAIT} cmd_state_e;

  // Scan / colour-order word for the output-control register.
  function automatic logic [VAL_W-1:0] mode_word(input logic [MODE_W-1:0] m);
    logic [VAL_W-1:0] w;
    w = OUT_BASE;
    w[8]  = m[0];
    w[9]  = m[1];
    w[11] = m[2];
    w[13] = m[3];
    return w;
  endfunction
endpackage

// File: rtl/panel_spi_shifter.sv
module panel_spi_shifter
  import panel_spi_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               fin,
  output logic               cs_n,
  output logic               sck,
  output logic               mosi
);
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int CNT_W   = $clog2(GAP_CYC + 1);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_W - 1);

  sh_state_e          st;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-1:0] sh;
  logic               tick_end;

  always_comb tick_end = (st == SH_GAP) ? (cnt == GAP_LAST) : (cnt == HALF_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SH_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      cs_n <= 1'b1;
      sck  <= 1'b1;
      mosi <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (st == SH_IDLE) begin
        if (start) begin
          sh   <= frame;
          mosi <= frame[FRAME_W-1];
          cs_n <= 1'b0;
          cnt  <= '0;
          st   <= SH_LEAD;
        end
      end else if (!tick_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          SH_LEAD: begin
            sck  <= 1'b0;
            mosi <= sh[FRAME_W-1];
            bitn <= '0;
            st   <= SH_LOW;
          end
          SH_LOW: begin
            sck <= 1'b1;
            st  <= SH_HIGH;
          end
          SH_HIGH: begin
            if (bitn == BIT_LAST) begin
              cs_n <= 1'b1;
              st   <= SH_GAP;
            end else begin
              sck  <= 1'b0;
              sh   <= {sh[FRAME_W-2:0], 1'b0};
              mosi <= sh[FRAME_W-2];
              bitn <= bitn + 1'b1;
              st   <= SH_LOW;
            end
          end
          SH_GAP: begin
            fin <= 1'b1;
            st  <= SH_IDLE;
          end
          default: st <= SH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/panel_frame_pair.sv
module panel_frame_pair
  import panel_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   index,
  input  logic [VAL_W-1:0]   value,
  input  logic               sh_fin,
  output logic               sh_start,
  output logic [FRAME_W-1:0] sh_frame,
  output logic               done
);
  pair_state_e      pst;
  logic [VAL_W-1:0] val_q;

  always_comb begin
    sh_start = ((pst == P_IDLE) && start) || ((pst == P_SEL) && sh_fin);
    if (pst == P_IDLE)
      sh_frame = {SEL_LEAD, (VAL_W-IDX_W)'(0), index};
    else
      sh_frame = {DAT_LEAD, val_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst   <= P_IDLE;
      val_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (pst)
        P_IDLE: if (start) begin
          val_q <= value;
          pst   <= P_SEL;
        end
        P_SEL: if (sh_fin) pst <= P_DAT;
        P_DAT: if (sh_fin) begin
          done <= 1'b1;
          pst  <= P_IDLE;
        end
        default: pst <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_cmd_source.sv
module panel_cmd_source
  import panel_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [VAL_W-1:0]  req_value,
  input  logic              pwr_on,
  input  logic              pwr_off,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              wr_done,
  output logic              req_ready,
  output logic              busy,
  output logic              wr_start,
  output logic [IDX_W-1:0]  wr_index,
  output logic [VAL_W-1:0]  wr_value
);
  cmd_state_e cst;

  always_comb begin
    req_ready = (cst == C_IDLE) && !pwr_on && !pwr_off;
    busy      = (cst != C_IDLE);
    wr_start  = 1'b0;
    wr_index  = req_index;
    wr_value  = req_value;
    case (cst)
      C_IDLE: begin
        if (pwr_on) begin
          wr_start = 1'b1;
          wr_index = PWR_REG;
          wr_value = PWR_WAKE;
        end else if (pwr_off) begin
          wr_start = 1'b1;
          wr_index = PWR_REG;
          wr_value = PWR_DOWN;
        end else begin
          wr_start = req_valid;
        end
      end
      C_ON_A: begin
        wr_start = wr_done;
        wr_index = OUT_REG;
        wr_value = mode_word(cfg_mode);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst <= C_IDLE;
    end else begin
      case (cst)
        C_IDLE: begin
          if (pwr_on) cst <= C_ON_A;
          else if (pwr_off || req_valid) cst <= C_WAIT;
        end
        C_ON_A:  if (wr_done) cst <= C_WAIT;
        C_WAIT:  if (wr_done) cst <= C_IDLE;
        default: cst <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_regwr_seq.sv
module panel_regwr_seq
  import panel_spi_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [VAL_W-1:0]  req_value,
  input  logic              pwr_on,
  input  logic              pwr_off,
  input  logic [MODE_W-1:0] cfg_mode,
  output logic              busy,
  output logic              done,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi
);
  logic               wr_start;
  logic [IDX_W-1:0]   wr_index;
  logic [VAL_W-1:0]   wr_value;
  logic               sh_start;
  logic [FRAME_W-1:0] sh_frame;
  logic               sh_fin;

  panel_cmd_source src_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_index(req_index),
    .req_value(req_value),
    .pwr_on   (pwr_on),
    .pwr_off  (pwr_off),
    .cfg_mode (cfg_mode),
    .wr_done  (done),
    .req_ready(req_ready),
    .busy     (busy),
    .wr_start (wr_start),
    .wr_index (wr_index),
    .wr_value (wr_value)
  );

  panel_frame_pair pair_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wr_start),
    .index   (wr_index),
    .value   (wr_value),
    .sh_fin  (sh_fin),
    .sh_start(sh_start),
    .sh_frame(sh_frame),
    .done    (done)
  );

  panel_spi_shifter #(.CLK_DIV(CLK_DIV)) shf_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(sh_start),
    .frame(sh_frame),
    .fin  (sh_fin),
    .cs_n (spi_cs_n),
    .sck  (spi_sck),
    .mosi (spi_mosi)
  );
endmodule

// File: rtl/panel_regwr_seq_chk.sv
module panel_regwr_seq_chk
  import panel_spi_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic pwr_on,
  input logic pwr_off,
  input logic busy,
  input logic done,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  localparam int GAP_MIN = 2 * CLK_DIV;
  localparam int HI_W    = $clog2(GAP_MIN + 1);

  logic [HI_W-1:0] hi_cnt;
  logic [5:0]      rise_cnt;
  logic            sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= HI_W'(GAP_MIN);
      rise_cnt <= '0;
      sck_q    <= 1'b1;
    end else begin
      sck_q <= spi_sck;
      if (spi_cs_n) begin
        rise_cnt <= '0;
        if (hi_cnt != HI_W'(GAP_MIN)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (spi_sck && !sck_q) rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  // R1 R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (rise_cnt == 6'(FRAME_W)));

  // R3
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sck);

  // R3
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sck && $past(spi_sck) && !$past(spi_cs_n)) |-> $stable(spi_mosi));

  // R4
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= HI_W'(GAP_MIN)));

  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R6
  frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R9
  pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on || pwr_off) |-> !req_ready);
endmodule

bind panel_regwr_seq panel_regwr_seq_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .pwr_on   (pwr_on),
  .pwr_off  (pwr_off),
  .busy     (busy),
  .done     (done),
  .spi_cs_n (spi_cs_n),
  .spi_sck  (spi_sck),
  .spi_mosi (spi_mosi)
);

// File: tb/panel_regwr_seq_tb_top.sv
`timescale 1ns/1ps
module panel_regwr_seq_tb_top;
  localparam int CLK_DIV = 2;
  localparam int GAP_MIN = 2 * CLK_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_index = '0;
  logic [15:0] req_value = '0;
  logic        pwr_on = 1'b0;
  logic        pwr_off = 1'b0;
  logic [3:0]  cfg_mode = '0;
  logic        busy, done, spi_cs_n, spi_sck, spi_mosi;

  int n_checks = 0;
  int n_errs = 0;
  int cyc = 0;

  logic [23:0] fr_q[$];
  int          nb_q[$];
  int          gap_q[$];

  always #5 clk = ~clk;

  panel_regwr_seq #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_value(req_value), .pwr_on(pwr_on),
    .pwr_off(pwr_off), .cfg_mode(cfg_mode), .busy(busy), .done(done),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Wire-level decoder: samples between clock edges.
  logic        prev_cs = 1'b1, prev_sck = 1'b1;
  logic [23:0] mon_sh = '0;
  int          mon_nb = 0;
  int          hi_run = 1000;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !spi_cs_n) begin
        gap_q.push_back(hi_run);
        mon_sh = '0;
        mon_nb = 0;
      end
      if (!spi_cs_n && spi_sck && !prev_sck) begin
        mon_sh = {mon_sh[22:0], spi_mosi};
        mon_nb++;
      end
      if (!prev_cs && spi_cs_n) begin
        fr_q.push_back(mon_sh);
        nb_q.push_back(mon_nb);
      end
      if (spi_cs_n) hi_run++;
      else hi_run = 0;
    end
    prev_cs  = spi_cs_n;
    prev_sck = spi_sck;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, {tag, " done pulse seen"}, 32'(done), 32'd1);
    chk(busy == 1'b1, {"R6 busy high with done ", tag}, 32'(busy), 32'd1);
  endtask

  task automatic expect_write(input logic [7:0] idx, input logic [15:0] val,
                              input string tag);
    logic [23:0] ea, eb, a, b;
    int na, nb, g;
    ea = {8'h74, 8'h00, idx};
    eb = {8'h76, val};
    if (fr_q.size() < 2 || gap_q.size() < 2) begin
      chk(1'b0, {"R1 R2 frame count ", tag}, 32'(fr_q.size()), 32'd2);
      fr_q.delete(); nb_q.delete(); gap_q.delete();
      return;
    end
    a = fr_q.pop_front(); na = nb_q.pop_front();
    b = fr_q.pop_front(); nb = nb_q.pop_front();
    g = gap_q.pop_front();
    g = gap_q.pop_front();
    chk(na == 24 && a == ea, {"R1 select frame ", tag}, {8'(na), a}, {8'd24, ea});
    chk(nb == 24 && b == eb, {"R2 data frame ", tag}, {8'(nb), b}, {8'd24, eb});
    chk(g >= GAP_MIN, {"R4 cs gap ", tag}, 32'(g), 32'(GAP_MIN));
  endtask

  task automatic send_req(input logic [7:0] idx, input logic [15:0] val,
                          input string tag);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_index = idx;
    req_value = val;
    @(negedge clk);
    req_valid = 1'b0;
    req_index = ~idx;
    req_value = ~val;
    chk(busy == 1'b1 && req_ready == 1'b0, {"R5 busy after accept ", tag},
        {busy, req_ready}, 2'b10);
    wait_done(tag);
    @(negedge clk);
    chk(busy == 1'b0, {"R6 busy falls after done ", tag}, 32'(busy), 32'd0);
    expect_write(idx, val, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(spi_cs_n && spi_sck && !busy && !done && req_ready, "R10 reset state",
        {spi_cs_n, spi_sck, busy, done, req_ready}, 5'b11001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && spi_sck && req_ready, "R10 idle after reset",
        {spi_cs_n, spi_sck, req_ready}, 3'b111);

    // R1 R2 R3 sweep over every index with derived values
    for (int i = 0; i < 256; i++) begin
      logic [7:0] ix;
      ix = 8'(i);
      send_req(ix, {ix ^ 8'h5A, ~ix}, "sweep");
    end
    send_req(8'h00, 16'h0000, "all-zero");
    send_req(8'hFF, 16'hFFFF, "all-one");
    send_req(8'h80, 16'h8001, "edge bits");

    // R7 power-on over all mode settings
    for (int m = 0; m < 16; m++) begin
      logic [15:0] ew;
      logic [3:0]  mb;
      mb = 4'(m);
      ew = 16'h00EF | (16'(mb[0]) << 8) | (16'(mb[1]) << 9)
                    | (16'(mb[2]) << 11) | (16'(mb[3]) << 13);
      cfg_mode = mb;
      pwr_on = 1'b1;
      #1;
      chk(req_ready == 1'b0, "R9 ready low during pwr_on", 32'(req_ready), 32'd0);
      @(negedge clk);
      pwr_on = 1'b0;
      wait_done("R7 wake");
      @(negedge clk);
      chk(busy == 1'b1, "R7 busy held between writes", 32'(busy), 32'd1);
      wait_done("R7 mode");
      @(negedge clk);
      chk(busy == 1'b0, "R7 busy low after sequence", 32'(busy), 32'd0);
      expect_write(8'h11, 16'h0000, "R7 wake write");
      expect_write(8'h01, ew, "R7 mode write");
    end

    // R8 power-off
    pwr_off = 1'b1;
    @(negedge clk);
    pwr_off = 1'b0;
    wait_done("R8");
    @(negedge clk);
    expect_write(8'h11, 16'h0001, "R8 shutdown write");

    // R9 pwr_off beats a pending stream request
    pwr_off = 1'b1;
    req_valid = 1'b1;
    req_index = 8'h33;
    req_value = 16'h1234;
    #1;
    chk(req_ready == 1'b0, "R9 ready low during pwr_off", 32'(req_ready), 32'd0);
    @(negedge clk);
    pwr_off = 1'b0;
    req_valid = 1'b0;
    wait_done("R9 off");
    @(negedge clk);
    expect_write(8'h11, 16'h0001, "R9 pwr_off over stream");

    // R9 pwr_on beats pwr_off
    cfg_mode = 4'b0101;
    pwr_on = 1'b1;
    pwr_off = 1'b1;
    @(negedge clk);
    pwr_on = 1'b0;
    pwr_off = 1'b0;
    wait_done("R9 on a");
    @(negedge clk);
    wait_done("R9 on b");
    @(negedge clk);
    expect_write(8'h11, 16'h0000, "R9 pwr_on first");
    expect_write(8'h01, 16'h09EF, "R9 pwr_on mode");

    // R9 power pulses ignored while busy
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_index = 8'h42;
    req_value = 16'hBEEF;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (50) @(negedge clk);
    pwr_on = 1'b1;
    @(negedge clk);
    pwr_on = 1'b0;
    pwr_off = 1'b1;
    @(negedge clk);
    pwr_off = 1'b0;
    wait_done("R9 ignore");
    @(negedge clk);
    expect_write(8'h42, 16'hBEEF, "R9 write during pulses");
    repeat (400) @(negedge clk);
    chk(fr_q.size() == 0 && busy == 1'b0, "R9 pulses ignored while busy",
        {fr_q.size() == 0, busy}, 2'b10);

    // R5 back-pressure: valid held across two requests
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_index = 8'hA1;
    req_value = 16'h0F0F;
    @(negedge clk);
    req_index = 8'hB2;
    req_value = 16'hF0F0;
    chk(req_ready == 1'b0, "R5 ready low while held", 32'(req_ready), 32'd0);
    wait_done("R5 first");
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R5 second");
    @(negedge clk);
    expect_write(8'hA1, 16'h0F0F, "R5 held first");
    expect_write(8'hB2, 16'hF0F0, "R5 held second");

    repeat (20) @(negedge clk);
    chk(spi_cs_n && spi_sck && !busy, "R3 idle levels at end",
        {spi_cs_n, spi_sck, busy}, 3'b110);
    summary();
    $finish;
  end
endmodule